// File: doc/BRIEF.md
# FIFO Output Stage with Serial/Parallel Extraction

This block is the extraction end of a FIFO slice. It watches the bottom word of the stack, takes that word into its output register on request, and presents it either as a parallel word on `q` or as a bit stream on `ser_out`. A one-cycle `stk_take` strobe tells the stack that the bottom word has been consumed. The `out_ready` flag is high while the register holds a word that the consumer has not yet taken.

In parallel mode the request input `xfer_par` works as a level, not as an edge. A word that reaches the bottom of the stack while the request is already high is still loaded. The same word is never loaded twice in one high period. Dropping the request clears the flag, but the data stays on `q`.

In serial mode the word is shifted out LSB first, one bit on each falling edge of `sclk`. The register counts as empty once the last bit has gone. If `out_ready` is fed back into the active-low `xfer_ser_n`, the stage fetches the next word on its own. When several slices run side by side, a slice strapped as a slave holds its flag low until its chain input goes high. This keeps the flags of the array in step.

Top module: `fifo_out_stage`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `out_ready`, `ser_oe` and `stk_take` are 0. `master_strap` is captured during reset.
- R2: A load happens at a clock edge where `stk_valid`=1, `xfer_par`=1, `xfer_ser_n`=0 and the stage is armed. After that edge `q` equals `stk_data`, `out_ready` is 1 for a master, and `stk_take` is 1 for exactly the following cycle.
- R3: In parallel mode (`ser_mode`=0), sampling `xfer_par`=0 drives `out_ready` to 0 after that edge. `q` keeps its word until the next load.
- R4: In parallel mode at most one word loads per high period of `xfer_par`. New stack data arriving during the same period causes no take and no change on `q`.
- R5: In parallel mode a word that becomes valid while `xfer_par` is still high loads at the next edge. A high pulse of `xfer_par` with no valid stack word leaves `out_ready` at 0.
- R6: While `xfer_ser_n`=1, no load happens in either mode.
- R7: In serial mode (`ser_mode`=1) a load sets `ser_oe`=1 and `out_ready`=1, with bit 0 of the word on `ser_out`. In parallel mode `ser_oe` stays 0.
- R8: In serial mode each falling edge of `sclk` (high at one clock edge, low at the next) moves the next higher bit onto `ser_out`. The fourth such edge makes `ser_oe`=0 and `out_ready`=0.
- R9: A falling `sclk` edge seen at the same clock edge as a load, or while the serial register is empty, shifts nothing.
- R10: In serial mode with `xfer_ser_n` tied to `out_ready`, the next stack word loads one clock after the last bit has been shifted out.
- R11: For a slice whose `master_strap` was 0 during reset, `out_ready` stays 0 after a load while `chain_in` is 0. It rises one edge after `chain_in` is sampled high.
- R12: `stk_take` is never high in two consecutive cycles.
- R13: `q_oe` follows `out_en` with one clock of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high master reset |
| ser_mode | input | 1 | 0 = parallel extraction, 1 = serial extraction |
| master_strap | input | 1 | 1 = slice is the master of its row (captured at reset) |
| stk_data | input | W | Bottom word of the stack |
| stk_valid | input | 1 | Bottom stack location holds a word |
| stk_take | output | 1 | One-cycle strobe: bottom word consumed |
| xfer_par | input | 1 | Level-sensitive transfer request |
| xfer_ser_n | input | 1 | Active-low serial transfer request |
| sclk | input | 1 | Serial output clock, shifting on falling edges |
| out_en | input | 1 | Parallel output enable |
| chain_in | input | 1 | Flag release from the neighbouring slice |
| q | output | W | Parallel data word |
| q_oe | output | 1 | Drive enable for `q` |
| ser_out | output | 1 | Serial data bit |
| ser_oe | output | 1 | Drive enable for `ser_out` |
| out_ready | output | 1 | Output register holds an unconsumed word |

## Verification
The hardest case to reach is a falling `sclk` edge that lands on the very clock edge of a serial load. From the ports this needs the serial clock to be held high while the register is empty and the request is withheld. The bench then drops `sclk` and asserts `xfer_ser_n` low in the same cycle, and counts that four more falls are still needed. The parallel duplicate-load guard is reached in a similar way. The bench pushes a second word while `xfer_par` stays high and confirms that the take counter and `q` do not move. The slave delay needs a reset taken with the strap low, followed by a load with the chain input held low.

// File: rtl/fo_pkg.sv
package fo_pkg;
  typedef enum logic {
    FO_PAR = 1'b0,
    FO_SER = 1'b1
  } fo_mode_e;
endpackage

// File: rtl/fo_edge_det.sv
module fo_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic sig_in,
  output logic fall_o
);
  logic sig_d;

  always_ff @(posedge clk) begin
    if (rst) sig_d <= 1'b0;
    else     sig_d <= sig_in;
  end

  assign fall_o = sig_d & ~sig_in;
endmodule

// File: rtl/fo_load_ctrl.sv
module fo_load_ctrl
  import fo_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ser_mode,
  input  logic stk_valid,
  input  logic xfer_par,
  input  logic xfer_ser_n,
  input  logic ser_busy,
  input  logic ser_busy_nxt,
  output logic load,
  output logic take,
  output logic hold_nxt
);
  fo_mode_e mode;
  logic     armed;
  logic     par_hold;
  logic     par_hold_nxt;
  logic     gate;

  assign mode = fo_mode_e'(ser_mode);

  // per-mode admission: parallel uses the per-high-period arm bit,
  // serial waits until the shifter has emptied
  always_comb begin
    gate = 1'b0;
    case (mode)
      FO_PAR:  gate = armed;
      FO_SER:  gate = ~ser_busy;
      default: gate = 1'b0;
    endcase
  end

  assign load = stk_valid & xfer_par & ~xfer_ser_n & gate;

  always_comb begin
    par_hold_nxt = par_hold;
    if (load)           par_hold_nxt = 1'b1;
    else if (!xfer_par) par_hold_nxt = 1'b0;
  end

  assign hold_nxt = (mode == FO_SER) ? ser_busy_nxt : par_hold_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed    <= 1'b1;
      par_hold <= 1'b0;
      take     <= 1'b0;
    end else begin
      take     <= load;
      par_hold <= par_hold_nxt;
      if (load)           armed <= 1'b0;
      else if (!xfer_par) armed <= 1'b1;
    end
  end
endmodule

// File: rtl/fo_shifter.sv
module fo_shifter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ser_mode,
  input  logic         load,
  input  logic         fall,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         ser_out,
  output logic         ser_busy,
  output logic         ser_busy_nxt
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(W);

  logic [W-1:0]  shreg;
  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_nxt;
  logic          shift;

  assign shift = ser_mode & fall & ~load & (cnt != '0);

  always_comb begin
    cnt_nxt = cnt;
    if (load && ser_mode) cnt_nxt = FULL_CNT;
    else if (shift)       cnt_nxt = cnt - 1'b1;
  end

  assign ser_busy_nxt = (cnt_nxt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      q        <= '0;
      shreg    <= '0;
      cnt      <= '0;
      ser_busy <= 1'b0;
    end else begin
      cnt      <= cnt_nxt;
      ser_busy <= ser_busy_nxt;
      if (load) begin
        q     <= din;
        shreg <= din;
      end else if (shift) begin
        shreg <= {1'b0, shreg[W-1:1]};
      end
    end
  end

  assign ser_out = shreg[0];
endmodule

// File: rtl/fo_flag.sv
module fo_flag (
  input  logic clk,
  input  logic rst,
  input  logic master_strap,
  input  logic chain_in,
  input  logic hold_nxt,
  output logic out_ready
);
  logic master_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      master_q  <= master_strap;
      out_ready <= 1'b0;
    end else begin
      out_ready <= hold_nxt & (master_q | chain_in);
    end
  end
endmodule

// File: rtl/fifo_out_stage.sv
module fifo_out_stage #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ser_mode,
  input  logic         master_strap,
  input  logic [W-1:0] stk_data,
  input  logic         stk_valid,
  output logic         stk_take,
  input  logic         xfer_par,
  input  logic         xfer_ser_n,
  input  logic         sclk,
  input  logic         out_en,
  input  logic         chain_in,
  output logic [W-1:0] q,
  output logic         q_oe,
  output logic         ser_out,
  output logic         ser_oe,
  output logic         out_ready
);
  logic fall;
  logic load;
  logic hold_nxt;
  logic busy;
  logic busy_nxt;

  fo_edge_det u_edge (
    .clk    (clk),
    .rst    (rst),
    .sig_in (sclk),
    .fall_o (fall)
  );

  fo_load_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .ser_mode     (ser_mode),
    .stk_valid    (stk_valid),
    .xfer_par     (xfer_par),
    .xfer_ser_n   (xfer_ser_n),
    .ser_busy     (busy),
    .ser_busy_nxt (busy_nxt),
    .load         (load),
    .take         (stk_take),
    .hold_nxt     (hold_nxt)
  );

  fo_shifter #(.W(W)) u_shift (
    .clk          (clk),
    .rst          (rst),
    .ser_mode     (ser_mode),
    .load         (load),
    .fall         (fall),
    .din          (stk_data),
    .q            (q),
    .ser_out      (ser_out),
    .ser_busy     (busy),
    .ser_busy_nxt (busy_nxt)
  );

  fo_flag u_flag (
    .clk          (clk),
    .rst          (rst),
    .master_strap (master_strap),
    .chain_in     (chain_in),
    .hold_nxt     (hold_nxt),
    .out_ready    (out_ready)
  );

  assign ser_oe = busy;

  always_ff @(posedge clk) begin
    if (rst) q_oe <= 1'b0;
    else     q_oe <= out_en;
  end
endmodule

// File: rtl/fifo_out_stage_chk.sv
module fifo_out_stage_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         ser_mode,
  input logic         master_strap,
  input logic [W-1:0] stk_data,
  input logic         stk_valid,
  input logic         stk_take,
  input logic         xfer_par,
  input logic         xfer_ser_n,
  input logic         sclk,
  input logic         out_en,
  input logic         chain_in,
  input logic [W-1:0] q,
  input logic         q_oe,
  input logic         ser_out,
  input logic         ser_oe,
  input logic         out_ready
);
  logic rst_q;
  logic strap_q;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) strap_q <= master_strap;
  end

  // R1: outputs quiet in the cycle after a reset edge
  always @(posedge clk) begin
    if (rst_q === 1'b1)
      p_reset_quiet_r1: assert (!out_ready && !ser_oe && !stk_take);
  end

  p_take_cause_r2: assert property (@(posedge clk) disable iff (rst)
    stk_take |-> $past(stk_valid && xfer_par && !xfer_ser_n));

  p_par_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (!ser_mode && !xfer_par) |=> !out_ready);

  p_q_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(q) |-> stk_take);

  p_no_req_r6: assert property (@(posedge clk) disable iff (rst)
    xfer_ser_n |=> !stk_take);

  p_ser_start_r7: assert property (@(posedge clk) disable iff (rst)
    (ser_mode && $rose(ser_oe)) |-> stk_take);

  p_ser_quiet_par_r7: assert property (@(posedge clk) disable iff (rst)
    !ser_mode |-> !ser_oe);

  p_slave_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (!strap_q && !chain_in) |=> !out_ready);

  p_take_single_r12: assert property (@(posedge clk) disable iff (rst)
    stk_take |=> !stk_take);

  p_qoe_follow_r13: assert property (@(posedge clk) disable iff (rst)
    out_en |=> q_oe);
endmodule

bind fifo_out_stage fifo_out_stage_chk #(.W(W)) u_chk (.*);

// File: tb/test_fifo_out_stage.sv
module test_fifo_out_stage;
  localparam int W = 4;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         ser_mode = 1'b0;
  logic         master_strap = 1'b1;
  logic [W-1:0] stk_data = '0;
  logic         stk_valid = 1'b0;
  logic         stk_take;
  logic         xfer_par = 1'b0;
  logic         xfer_ser_n;
  logic         ser_req_n = 1'b0;
  logic         tie = 1'b0;
  logic         sclk = 1'b0;
  logic         out_en = 1'b0;
  logic         chain_in = 1'b1;
  logic [W-1:0] q;
  logic         q_oe;
  logic         ser_out;
  logic         ser_oe;
  logic         out_ready;

  int checks = 0;
  int fails  = 0;
  int takes  = 0;
  logic [W-1:0] stack_q[$];
  logic [W-1:0] exp_q[$];
  logic         rdy_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign xfer_ser_n = tie ? out_ready : ser_req_n;

  fifo_out_stage #(.W(W)) i_fifo_out_stage (
    .clk(clk), .rst(rst), .ser_mode(ser_mode), .master_strap(master_strap),
    .stk_data(stk_data), .stk_valid(stk_valid), .stk_take(stk_take),
    .xfer_par(xfer_par), .xfer_ser_n(xfer_ser_n), .sclk(sclk),
    .out_en(out_en), .chain_in(chain_in), .q(q), .q_oe(q_oe),
    .ser_out(ser_out), .ser_oe(ser_oe), .out_ready(out_ready)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic void refresh();
    stk_valid = (stack_q.size() != 0);
    stk_data  = (stack_q.size() != 0) ? stack_q[0] : '0;
  endfunction

  // driver: one word into the stack model and the scoreboard
  task automatic push_word(input logic [W-1:0] w);
    stack_q.push_back(w);
    exp_q.push_back(w);
    refresh();
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input logic mode, input logic strap);
    rst = 1'b1;
    ser_mode = mode;
    master_strap = strap;
    tick();
    tick();
    stack_q.delete();
    exp_q.delete();
    refresh();
    rst = 1'b0;
  endtask

  task automatic shift_bit();
    sclk = 1'b1;
    tick();
    sclk = 1'b0;
    tick();
  endtask

  // stack model and monitor, both on the falling clock edge
  always @(negedge clk) begin
    if (rst) begin
      rdy_prev = 1'b0;
    end else begin
      if (stk_take) begin
        takes++;
        if (stack_q.size() != 0) void'(stack_q.pop_front());
        refresh();
      end
      if (out_ready && !rdy_prev) begin
        if (exp_q.size() == 0) chk("R2 unexpected word", {28'd0, q}, 32'hFFFF);
        else chk("R2 scoreboard word", {28'd0, q}, {28'd0, exp_q.pop_front()});
      end
      rdy_prev = out_ready;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int t0;
    logic [W-1:0] w;
    @(negedge clk);
    // ---- parallel master ----
    do_reset(1'b0, 1'b1);
    chk("R1 out_ready", out_ready, 0);
    chk("R1 ser_oe", ser_oe, 0);
    chk("R1 take", stk_take, 0);
    out_en = 1'b1;
    tick();
    chk("R13 q_oe on", q_oe, 1);
    out_en = 1'b0;
    tick();
    chk("R13 q_oe off", q_oe, 0);

    ser_req_n = 1'b0;
    t0 = takes;
    push_word(4'hA);
    xfer_par = 1'b1;
    tick();
    chk("R2 ready", out_ready, 1);
    chk("R2 q", q, 4'hA);
    chk("R2 take pulse", stk_take, 1);
    tick();
    chk("R12 take one cycle", stk_take, 0);
    chk("R2 take count", takes - t0, 1);

    push_word(4'h5);
    t0 = takes;
    tick(); tick(); tick();
    chk("R4 no second take", takes - t0, 0);
    chk("R4 q held", q, 4'hA);
    chk("R7 par ser_oe", ser_oe, 0);

    xfer_par = 1'b0;
    tick();
    chk("R3 ready cleared", out_ready, 0);
    chk("R3 q kept", q, 4'hA);
    xfer_par = 1'b1;
    tick();
    chk("R3 next load", q, 4'h5);
    xfer_par = 1'b0;
    tick();

    // pulse without data
    xfer_par = 1'b1;
    tick();
    chk("R5 pulse no data", out_ready, 0);
    xfer_par = 1'b0;
    tick();
    chk("R5 after pulse", out_ready, 0);
    // data arrives during the high level
    xfer_par = 1'b1;
    tick(); tick();
    push_word(4'hC);
    tick();
    chk("R5 late data ready", out_ready, 1);
    chk("R5 late data q", q, 4'hC);
    xfer_par = 1'b0;
    tick();

    // request withheld
    push_word(4'h3);
    ser_req_n = 1'b1;
    xfer_par = 1'b1;
    t0 = takes;
    tick(); tick(); tick();
    chk("R6 no take", takes - t0, 0);
    chk("R6 not ready", out_ready, 0);
    ser_req_n = 1'b0;
    tick();
    chk("R6 loads once allowed", q, 4'h3);
    xfer_par = 1'b0;
    tick();

    // ---- parallel slave ----
    chain_in = 1'b0;
    do_reset(1'b0, 1'b0);
    master_strap = 1'b1;
    push_word(4'h9);
    xfer_par = 1'b1;
    t0 = takes;
    tick();
    chk("R11 slave held low", out_ready, 0);
    tick();
    chk("R11 slave loaded", takes - t0, 1);
    chk("R11 slave still low", out_ready, 0);
    chain_in = 1'b1;
    tick();
    chk("R11 slave released", out_ready, 1);
    xfer_par = 1'b0;
    tick();

    // ---- serial master ----
    do_reset(1'b1, 1'b1);
    xfer_par = 1'b1;
    ser_req_n = 1'b0;
    w = 4'b1011;
    push_word(w);
    tick();
    ser_req_n = 1'b1;
    chk("R7 ser_oe", ser_oe, 1);
    chk("R7 ready", out_ready, 1);
    chk("R7 first bit", ser_out, w[0]);
    for (int i = 1; i < W; i++) begin
      shift_bit();
      chk("R8 bit", ser_out, w[i]);
      chk("R8 still driven", ser_oe, 1);
    end
    shift_bit();
    chk("R8 ser_oe off", ser_oe, 0);
    chk("R8 empty", out_ready, 0);

    // falls while empty
    shift_bit();
    shift_bit();
    w = 4'b0110;
    push_word(w);
    ser_req_n = 1'b0;
    tick();
    ser_req_n = 1'b1;
    chk("R9 empty falls ignored", ser_out, w[0]);
    for (int i = 1; i < W; i++) begin
      shift_bit();
      chk("R9 bit after empty falls", ser_out, w[i]);
    end
    shift_bit();
    chk("R9 drained", ser_oe, 0);

    // fall on the load edge
    w = 4'b1101;
    push_word(w);
    sclk = 1'b1;
    tick();
    sclk = 1'b0;
    ser_req_n = 1'b0;
    tick();
    ser_req_n = 1'b1;
    chk("R9 load-edge fall ignored", ser_out, w[0]);
    for (int i = 1; i < W; i++) begin
      shift_bit();
      chk("R9 bit after load fall", ser_out, w[i]);
    end
    chk("R9 still driven before 4th", ser_oe, 1);
    shift_bit();
    chk("R9 off after 4th", ser_oe, 0);

    // automatic refill
    push_word(4'b0011);
    push_word(4'b1000);
    tie = 1'b1;
    tick();
    for (int k = 0; k < 2; k++) begin
      w = (k == 0) ? 4'b0011 : 4'b1000;
      chk("R10 auto load", ser_oe, 1);
      chk("R10 first bit", ser_out, w[0]);
      for (int i = 1; i < W; i++) begin
        shift_bit();
        chk("R10 bit", ser_out, w[i]);
      end
      shift_bit();
      chk("R10 drained", out_ready, 0);
      tick();
    end
    tie = 1'b0;
    ser_req_n = 1'b1;
    chk("R10 stack empty at end", ser_oe, 0);
    tick();
    chk("R2 scoreboard drained", exp_q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule